// File: doc/BRIEF.md
# Periodic Tick and Square-Wave Generator

This block sits in the 32.768 kHz domain of a real-time clock. A free-running binary divider chain counts input clock cycles. A 4-bit rate code picks one stage of that chain. From the chosen stage the block derives two outputs:

- a single-cycle tick, which a separate interrupt-flag latch consumes;
- a square wave with 50 % duty, which leaves the chip when its enable is set.

While the countdown logic holds its divider, the chain is held cleared. Every rate therefore restarts from a known phase when the hold is released.

The rate code is not monotonic:

| Rate codes | Result |
| --- | --- |
| 0 | Both outputs off |
| 3 to 7 | Fast rates, 8192 Hz down to 512 Hz |
| 8 to 15 | Slow rates, 256 Hz down to 2 Hz |
| 1 and 2 | Same as codes 8 and 9 |

Software that reads the time between ticks has half a tick period, plus the short pre-update delay, before the next update can interfere.

Top module: `rtc_tick_sqw`

## Requirements
- R1: Rate code 4'b0000 produces no tick and keeps the square wave low, whatever the enable.
- R2: Rate codes 3, 4, 5, 6 and 7 give tick and square-wave periods of 4, 8, 16, 32 and 64 input cycles (8192, 4096, 2048, 1024 and 512 Hz from 32.768 kHz).
- R3: Rate codes 8 through 15 give periods of 128, 256, 512, 1024, 2048, 4096, 8192 and 16384 input cycles (256 Hz down to 2 Hz, a 500 ms period for code 15).
- R4: Rate code 1 behaves exactly as code 8 (128 cycles), and rate code 2 behaves exactly as code 9 (256 cycles).
- R5: The tick is high for exactly one input cycle per period. It rises in the cycle where the selected divider stage goes from 0 to 1, which is P/2 cycles into each period of P cycles counted from a cleared chain.
- R6: The square wave is high for the second half of each period (50 % duty) when the enable is 1. It is held low when the enable is 0, and the tick is not affected by the enable.
- R7: While the divider hold is 1, the chain stays at zero and both outputs are low from the next cycle on. After the hold is released, the first tick comes exactly P/2 cycles later.
- R8: An active-low reset clears the chain at once, so both outputs are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_32k | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| div_hold | input | 1 | Holds the divider chain cleared while 1 |
| rate_sel | input | 4 | Rate code selecting the tick and square-wave rate |
| sqw_en | input | 1 | Square-wave output enable |
| tick_pulse | output | 1 | One-cycle periodic tick for the interrupt-flag logic |
| sqw_out | output | 1 | Square-wave output, low when disabled |

## Verification
The bench builds the block with its default fastest-stage parameter, which makes the chain 14 stages deep. With that value the slowest rate, 2 Hz, has a period of 16384 cycles. The bench can therefore compare every cycle across two full periods of each of the sixteen codes against a cycle-exact expected waveform. It does the same with the enable low, and around a hold and a reset in the middle of a run. This covers the aliased codes and the exact first-tick position after a cleared chain.

// File: rtl/rtc_tick_pkg.sv
`timescale 1ns/1ps
package rtc_tick_pkg;

  localparam int unsigned RATE_W    = 4;
  localparam int unsigned TAP_IDX_W = 5;  // chain depth must stay <= 32

  typedef logic [RATE_W-1:0] rate_code_t;

  typedef struct packed {
    logic                 valid;
    logic [TAP_IDX_W-1:0] tap;
  } tap_sel_t;

  // Map a rate code to a divider stage index.
  // Code 3 selects fast_tap; each higher code selects one slower stage.
  // Codes 1 and 2 alias to the stages of codes 8 and 9.
  function automatic tap_sel_t rate_to_tap(input rate_code_t code, input int fast_tap);
    tap_sel_t r;
    int       t;
    t       = 0;
    r.valid = (code != '0);
    if (code == '0)
      t = 0;
    else if (code < 4'd3)
      t = fast_tap + int'(code) + 4;
    else
      t = fast_tap + int'(code) - 3;
    r.tap = TAP_IDX_W'(t);
    return r;
  endfunction

endpackage

// File: rtl/rtc_tick_decode.sv
`timescale 1ns/1ps
module rtc_tick_decode
  import rtc_tick_pkg::*;
#(
  parameter int FAST_TAP = 1
) (
  input  rate_code_t rate_sel,
  output tap_sel_t   sel
);

  always_comb begin
    sel = rate_to_tap(rate_sel, FAST_TAP);
  end

endmodule

// File: rtl/rtc_tick_chain.sv
`timescale 1ns/1ps
module rtc_tick_chain #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] carry;

  assign carry[0] = 1'b1;

  // One toggle stage per bit; a stage toggles when all lower stages are 1.
  generate
    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
      if (k < CNT_W - 1) begin : g_carry
        assign carry[k+1] = carry[k] & cnt_q[k];
      end
      assign cnt_d[k] = hold ? 1'b0 : (cnt_q[k] ^ carry[k]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R7: a free-running chain advances by exactly one each cycle
  p_chain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R7: the hold clears the chain
  p_chain_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_tick_mux.sv
`timescale 1ns/1ps
module rtc_tick_mux
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  tap_sel_t         sel,
  input  logic             sqw_en,
  output logic             pulse,
  output logic             sqw
);

  localparam int EXT_N = 1 << TAP_IDX_W;

  logic [EXT_N-1:0] tap_ext;
  logic             tap_now;
  logic             tap_prev_q;
  logic             tap_prev_d;

  // Widen the chain to the full index range; unused indices read as 0.
  generate
    for (genvar i = 0; i < EXT_N; i++) begin : g_ext
      if (i < CNT_W) begin : g_live
        assign tap_ext[i] = cnt[i];
      end else begin : g_pad
        assign tap_ext[i] = 1'b0;
      end
    end
  endgenerate

  assign tap_now    = sel.valid & tap_ext[sel.tap];
  assign tap_prev_d = tap_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_prev_q <= 1'b0;
    else        tap_prev_q <= tap_prev_d;
  end

  assign pulse = tap_now & ~tap_prev_q;
  assign sqw   = tap_now & sqw_en;

  // R5: the tick never lasts more than one cycle (shortest period is 4)
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/rtc_tick_sqw.sv
`timescale 1ns/1ps
module rtc_tick_sqw
  import rtc_tick_pkg::*;
#(
  parameter int FAST_TAP = 1
) (
  input  logic       clk_32k,
  input  logic       rst_n,
  input  logic       div_hold,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  output logic       tick_pulse,
  output logic       sqw_out
);

  localparam int CNT_W = FAST_TAP + 13;

  logic [CNT_W-1:0] chain;
  tap_sel_t         sel;

  rtc_tick_decode #(.FAST_TAP(FAST_TAP)) u_decode (
    .rate_sel (rate_sel),
    .sel      (sel)
  );

  rtc_tick_chain #(.CNT_W(CNT_W)) u_chain (
    .clk   (clk_32k),
    .rst_n (rst_n),
    .hold  (div_hold),
    .cnt   (chain)
  );

  rtc_tick_mux #(.CNT_W(CNT_W)) u_mux (
    .clk    (clk_32k),
    .rst_n  (rst_n),
    .cnt    (chain),
    .sel    (sel),
    .sqw_en (sqw_en),
    .pulse  (tick_pulse),
    .sqw    (sqw_out)
  );

  // R5: with a steady code and enable, a tick marks the square wave rising
  p_tick_on_rise_r5: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (tick_pulse && sqw_en && rate_sel != 4'd0 && $stable(rate_sel) && $stable(sqw_en))
      |-> (sqw_out && !$past(sqw_out)));

  // R1: a steady off code keeps both outputs quiet
  p_off_quiet_r1: assert property (@(posedge clk_32k) disable iff (!rst_n)
    (rate_sel == 4'd0 && $past(rate_sel) == 4'd0) |-> (!tick_pulse && !sqw_out));

  // R7: one cycle after a hold both outputs are low
  p_hold_quiet_r7: assert property (@(posedge clk_32k) disable iff (!rst_n)
    div_hold |=> (!tick_pulse && !sqw_out));

endmodule

// File: tb/rtc_tick_sqw_tb.sv
`timescale 1ns/1ps
module rtc_tick_sqw_tb;

  logic       clk_32k;
  logic       rst_n;
  logic       div_hold;
  logic [3:0] rate_sel;
  logic       sqw_en;
  logic       tick_pulse;
  logic       sqw_out;

  int n_tests;
  int n_fail;
  bit done;

  rtc_tick_sqw u_dut (
    .clk_32k    (clk_32k),
    .rst_n      (rst_n),
    .div_hold   (div_hold),
    .rate_sel   (rate_sel),
    .sqw_en     (sqw_en),
    .tick_pulse (tick_pulse),
    .sqw_out    (sqw_out)
  );

  initial clk_32k = 1'b0;
  always #5 clk_32k = ~clk_32k;

  // {code[20:17], enable[16], period[15:0]}; a period of 0 means no output
  localparam logic [20:0] VEC [17] = '{
    {4'd0,  1'b1, 16'd0},
    {4'd1,  1'b1, 16'd128},
    {4'd2,  1'b1, 16'd256},
    {4'd3,  1'b1, 16'd4},
    {4'd4,  1'b1, 16'd8},
    {4'd5,  1'b1, 16'd16},
    {4'd6,  1'b1, 16'd32},
    {4'd7,  1'b1, 16'd64},
    {4'd8,  1'b1, 16'd128},
    {4'd9,  1'b1, 16'd256},
    {4'd10, 1'b1, 16'd512},
    {4'd11, 1'b1, 16'd1024},
    {4'd12, 1'b1, 16'd2048},
    {4'd13, 1'b1, 16'd4096},
    {4'd14, 1'b1, 16'd8192},
    {4'd15, 1'b1, 16'd16384},
    {4'd3,  1'b0, 16'd4}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int code, input bit en);
    if (!en)        return "R6";
    if (code == 0)  return "R1";
    if (code < 3)   return "R4";
    if (code < 8)   return "R2";
    return "R3";
  endfunction

  // Compare sample i (i-th falling edge after release) against the
  // expected waveform: tick at i mod P == P/2, wave high for the upper half.
  task automatic run_window(input int per, input bit en, input int win,
                            input string req);
    int bad_p, bad_s, act_p, exp_p, act_s, exp_s;
    bad_p = 0; bad_s = 0; act_p = 0; exp_p = 0; act_s = 0; exp_s = 0;
    for (int i = 1; i <= win; i++) begin
      bit ep, es;
      @(negedge clk_32k);
      ep = (per != 0) && ((i % per) == per / 2);
      es = (per != 0) && en && ((i % per) >= per / 2);
      if (tick_pulse !== ep && bad_p == 0) begin
        bad_p = i; act_p = int'(tick_pulse); exp_p = int'(ep);
      end
      if (sqw_out !== es && bad_s == 0) begin
        bad_s = i; act_s = int'(sqw_out); exp_s = int'(es);
      end
    end
    check(bad_p == 0, req, $sformatf("R5 tick waveform, first bad sample %0d", bad_p),
          act_p, exp_p);
    check(bad_s == 0, req, $sformatf("R6 square wave, first bad sample %0d", bad_s),
          act_s, exp_s);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; div_hold = 1'b0; rate_sel = 4'd3; sqw_en = 1'b1;

    // R8: reset state
    repeat (3) @(negedge clk_32k);
    check(tick_pulse === 1'b0, "R8", "tick in reset", int'(tick_pulse), 0);
    check(sqw_out === 1'b0, "R8", "wave in reset", int'(sqw_out), 0);
    rst_n = 1'b1;

    // Table walk: hold one edge, set the code, release, compare two periods
    foreach (VEC[v]) begin
      int  code, per;
      bit  en;
      code = int'(VEC[v][20:17]);
      en   = VEC[v][16];
      per  = int'(VEC[v][15:0]);
      @(negedge clk_32k);
      div_hold = 1'b1; rate_sel = 4'(code); sqw_en = en;
      @(negedge clk_32k);
      div_hold = 1'b0;
      run_window(per, en, (per == 0) ? 600 : 2 * per + 3, req_of(code, en));
    end

    // R7: hold in mid-run keeps outputs low, then realigns the phase
    @(negedge clk_32k);
    rate_sel = 4'd4; sqw_en = 1'b1; div_hold = 1'b0;
    repeat (13) @(negedge clk_32k);
    div_hold = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_32k);
      check(tick_pulse === 1'b0 && sqw_out === 1'b0, "R7", "outputs during hold",
            int'({tick_pulse, sqw_out}), 0);
    end
    div_hold = 1'b0;
    run_window(8, 1'b1, 20, "R7");

    // R1: code 0 with enable high stays quiet over a long stretch
    @(negedge clk_32k);
    rate_sel = 4'd0;
    run_window(0, 1'b1, 300, "R1");

    // R8: asynchronous reset in mid-run, then a fresh phase
    @(negedge clk_32k);
    rate_sel = 4'd3; sqw_en = 1'b1;
    repeat (7) @(negedge clk_32k);
    rst_n = 1'b0;
    #1;
    check(tick_pulse === 1'b0, "R8", "tick after async reset", int'(tick_pulse), 0);
    check(sqw_out === 1'b0, "R8", "wave after async reset", int'(sqw_out), 0);
    @(negedge clk_32k);
    rst_n = 1'b1;
    run_window(4, 1'b1, 12, "R8");

    done = 1'b1;
    finish_run();
  end

endmodule